// File: doc/BRIEF.md
# Vectored Bus Interrupt Requester

This block lets a peripheral interrupt a processor over an asynchronous multi-master bus that uses request/grant arbitration. When the device reports that it has finished and software has enabled interrupts, the block raises a bus request on one priority level, which is fixed by a parameter. It then watches the matching grant line. If the grant arrives while its own request is pending, the block claims it with a selection acknowledge and keeps the grant from travelling further down the daisy chain. It then waits for the bus to go idle and takes bus ownership by asserting bus busy.

While it owns the bus, the block drives the interrupt line and places a configurable interrupt vector on data bits 8:2. The processor answers with slave sync. On the rising edge of slave sync the block releases bus busy, the interrupt line and the vector. The request then stays blocked until the done input falls and rises again, so one completion produces exactly one interrupt.

All bus inputs are taken as already synchronised to `clk`. The asynchronous handshake is followed as a sequence of clocked events: grant edges, the idle bus and slave sync edges.

Top module: `irq_bus_requester`

## Requirements
- R1: `br_o` is nonzero exactly when done and interrupt enable are both high, selection acknowledge and busy ownership are both clear, no post-interrupt inhibit is pending, and init is low. This is evaluated combinationally from the current inputs and state.
- R2: The request appears only on bit `PRI_LEVEL-4` of `br_o`, so the default level 5 is bit 1. All other bits stay 0.
- R3: The rising edge of the matching grant line sets `sack_o` at that clock edge only if the request was active. A grant edge with no request leaves `sack_o` at 0.
- R4: With `sack_o` set, busy ownership is taken at the first clock edge where bus-busy-in, slave sync and the matching grant are all low. At that edge `sack_o` clears and `bbsy_o` sets. If any of the three is high, `sack_o` holds and `bbsy_o` stays 0.
- R5: While `bbsy_o` is 1, `intr_o` is 1 and `data_o` holds `VECTOR[8:2]` in bits 8:2 with all other bits 0. The default vector 264 octal gives `data_o` = 16'h00B4. While `bbsy_o` is 0, both `intr_o` and `data_o` are 0.
- R6: A rising edge of slave sync while owning the bus clears `bbsy_o` at that clock edge. The request then stays low even with done and enable high, until done has been low for at least one clock edge and then rises again.
- R7: Init held high at a clock edge clears selection acknowledge, busy ownership, the grant claim and the inhibit. Init also forces `br_o` to 0 while it is high.
- R8: A grant line is copied to `bg_out_o` unless it belongs to this block's level while the block is requesting or has claimed that grant. The claim lasts from the claiming grant edge until the grant is seen low at a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_i | input | 1 | Bus initialise, synchronous clear |
| done_i | input | 1 | Device has finished its function |
| int_en_i | input | 1 | Interrupts enabled by software |
| bg_in_i | input | NUM_LEVELS | Grant lines arriving from upstream, one per level |
| bbsy_in_i | input | 1 | Bus busy as seen on the bus (other masters) |
| ssyn_in_i | input | 1 | Slave sync from the processor |
| br_o | output | NUM_LEVELS | Bus request lines, one per level |
| bg_out_o | output | NUM_LEVELS | Grant lines passed downstream |
| sack_o | output | 1 | Selection acknowledge |
| bbsy_o | output | 1 | Bus busy driven by this block |
| intr_o | output | 1 | Interrupt line |
| data_o | output | 16 | Data lines carrying the vector |

## Verification
Each state bit of this block shows up at the ports within one clock edge. A stuck or spurious selection acknowledge shows up at once as a missing request or a missing bus-busy. A wrong busy flip-flop shows on `bbsy_o`, `intr_o` and the vector together in the same cycle. A lost inhibit shows as a second request in the cycle right after release. A claim that is wrong, in either direction, appears on the passed-on grant as soon as the grant rises. The stimulus therefore walks the whole handshake one edge at a time and compares every observable output after each edge. It also holds each idle-bus qualifier high on its own, to show that ownership waits for all three.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned LEVEL_BASE = 4;
  localparam int unsigned DATA_W     = 16;

  // Place vector bits 8:2 on the data lines, everything else zero.
  function automatic logic [DATA_W-1:0] vector_word(input logic [8:0] vec, input logic own);
    logic [DATA_W-1:0] w;
    w = '0;
    if (own) w[8:2] = vec[8:2];
    return w;
  endfunction

  // Bus idle: no other master busy and no slave sync outstanding.
  function automatic logic bus_is_idle(input logic bbsy_in, input logic ssyn_in);
    return !bbsy_in && !ssyn_in;
  endfunction
endpackage

// File: rtl/irq_edge.sv
module irq_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic rise,
  output logic level
);
  logic q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= d;
  end
  assign rise  = d && !q;
  assign level = d;
endmodule

// File: rtl/irq_handshake.sv
module irq_handshake (
  input  logic clk,
  input  logic rst_n,
  input  logic init,
  input  logic done,
  input  logic int_en,
  input  logic grant_lvl,
  input  logic grant_rise,
  input  logic bus_idle,
  input  logic ssyn_rise,
  output logic request,
  output logic sack,
  output logic own,
  output logic claim,
  output logic take_evt,
  output logic release_evt
);
  logic inhibit;

  assign request     = done && int_en && !sack && !own && !inhibit && !init;
  assign take_evt    = sack && bus_idle && !grant_lvl;
  assign release_evt = own && ssyn_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sack    <= 1'b0;
      own     <= 1'b0;
      claim   <= 1'b0;
      inhibit <= 1'b0;
    end else if (init) begin
      sack    <= 1'b0;
      own     <= 1'b0;
      claim   <= 1'b0;
      inhibit <= 1'b0;
    end else begin
      if (grant_rise && request) begin
        sack  <= 1'b1;
        claim <= 1'b1;
      end else if (!grant_lvl) begin
        claim <= 1'b0;
      end
      if (take_evt) begin
        sack <= 1'b0;
        own  <= 1'b1;
      end else if (release_evt) begin
        own  <= 1'b0;
      end
      if (release_evt)  inhibit <= 1'b1;
      else if (!done)   inhibit <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_bus_drive.sv
module irq_bus_drive #(
  parameter int unsigned NUM_LEVELS = 4,
  parameter int unsigned LVL_IDX    = 1,
  parameter logic [8:0]  VECTOR     = 9'o264
) (
  input  logic                  request,
  input  logic                  claim,
  input  logic                  own,
  input  logic [NUM_LEVELS-1:0] bg_in,
  output logic [NUM_LEVELS-1:0] br,
  output logic [NUM_LEVELS-1:0] bg_out,
  output logic                  intr,
  output logic [15:0]           data
);
  for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_lvl
    if (l == LVL_IDX) begin : g_mine
      assign br[l]     = request;
      assign bg_out[l] = bg_in[l] && !claim && !request;
    end else begin : g_other
      assign br[l]     = 1'b0;
      assign bg_out[l] = bg_in[l];
    end
  end
  assign intr = own;
  assign data = irq_pkg::vector_word(VECTOR, own);
endmodule

// File: rtl/irq_bus_requester.sv
module irq_bus_requester #(
  parameter int unsigned NUM_LEVELS = 4,
  parameter int unsigned PRI_LEVEL  = 5,
  parameter logic [8:0]  VECTOR     = 9'o264
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  init_i,
  input  logic                  done_i,
  input  logic                  int_en_i,
  input  logic [NUM_LEVELS-1:0] bg_in_i,
  input  logic                  bbsy_in_i,
  input  logic                  ssyn_in_i,
  output logic [NUM_LEVELS-1:0] br_o,
  output logic [NUM_LEVELS-1:0] bg_out_o,
  output logic                  sack_o,
  output logic                  bbsy_o,
  output logic                  intr_o,
  output logic [15:0]           data_o
);
  localparam int unsigned LVL_IDX = PRI_LEVEL - irq_pkg::LEVEL_BASE;

  logic grant_lvl, grant_rise, ssyn_rise, ssyn_lvl, bus_idle;
  logic request, claim, own, take_evt, release_evt;

  irq_edge u_grant_edge (
    .clk(clk), .rst_n(rst_n), .d(bg_in_i[LVL_IDX]), .rise(grant_rise), .level(grant_lvl)
  );
  irq_edge u_ssyn_edge (
    .clk(clk), .rst_n(rst_n), .d(ssyn_in_i), .rise(ssyn_rise), .level(ssyn_lvl)
  );

  assign bus_idle = irq_pkg::bus_is_idle(bbsy_in_i, ssyn_lvl);

  irq_handshake u_hs (
    .clk(clk), .rst_n(rst_n), .init(init_i), .done(done_i), .int_en(int_en_i),
    .grant_lvl(grant_lvl), .grant_rise(grant_rise), .bus_idle(bus_idle),
    .ssyn_rise(ssyn_rise), .request(request), .sack(sack_o), .own(own),
    .claim(claim), .take_evt(take_evt), .release_evt(release_evt)
  );

  irq_bus_drive #(.NUM_LEVELS(NUM_LEVELS), .LVL_IDX(LVL_IDX), .VECTOR(VECTOR)) u_drive (
    .request(request), .claim(claim), .own(own), .bg_in(bg_in_i),
    .br(br_o), .bg_out(bg_out_o), .intr(intr_o), .data(data_o)
  );

  assign bbsy_o = own;
endmodule

// File: rtl/irq_bus_requester_chk.sv
module irq_bus_requester_chk #(
  parameter int unsigned NUM_LEVELS = 4,
  parameter int unsigned LVL_IDX    = 1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  init_i,
  input logic                  done_i,
  input logic                  int_en_i,
  input logic [NUM_LEVELS-1:0] bg_in_i,
  input logic                  bbsy_in_i,
  input logic                  ssyn_in_i,
  input logic [NUM_LEVELS-1:0] br_o,
  input logic [NUM_LEVELS-1:0] bg_out_o,
  input logic                  sack_o,
  input logic                  bbsy_o,
  input logic                  intr_o,
  input logic [15:0]           data_o,
  input logic                  grant_rise,
  input logic                  take_evt,
  input logic                  release_evt
);
  // R1: a request needs done and enable
  a_r1_req_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    (br_o != '0) |-> (done_i && int_en_i && !init_i));
  // R2: at most one level requested
  a_r2_one_level: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(br_o));
  // R3: selection acknowledge only after a grant edge with a request
  a_r3_sack_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sack_o) |-> $past(grant_rise && (br_o != '0)));
  // R4: ownership only from an idle bus with no grant
  a_r4_take_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bbsy_o) |-> $past(sack_o && !bbsy_in_i && !ssyn_in_i && !bg_in_i[LVL_IDX]));
  // R5: interrupt and vector only while owning the bus
  a_r5_vector_only_owned: assert property (@(posedge clk) disable iff (!rst_n)
    !bbsy_o |-> (data_o == 16'h0000 && !intr_o));
  // R6: release follows slave sync edge and no immediate re-request
  a_r6_release_no_rereq: assert property (@(posedge clk) disable iff (!rst_n)
    release_evt |=> (!bbsy_o && br_o == '0));
  // R7: init clears the handshake
  a_r7_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
    init_i |=> (!sack_o && !bbsy_o));
  // R8: a claimed grant is not passed on
  a_r8_block_claimed: assert property (@(posedge clk) disable iff (!rst_n)
    sack_o |-> !bg_out_o[LVL_IDX]);
  // R4: take event and release never coincide
  a_r4_take_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(take_evt && release_evt));
endmodule

bind irq_bus_requester irq_bus_requester_chk #(
  .NUM_LEVELS(NUM_LEVELS), .LVL_IDX(LVL_IDX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .init_i(init_i), .done_i(done_i), .int_en_i(int_en_i),
  .bg_in_i(bg_in_i), .bbsy_in_i(bbsy_in_i), .ssyn_in_i(ssyn_in_i),
  .br_o(br_o), .bg_out_o(bg_out_o), .sack_o(sack_o), .bbsy_o(bbsy_o),
  .intr_o(intr_o), .data_o(data_o), .grant_rise(grant_rise),
  .take_evt(take_evt), .release_evt(release_evt)
);

// File: tb/irq_bus_requester_bench.sv
module irq_bus_requester_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NLV = 4;
  localparam int LVL = 1;
  localparam logic [15:0] VEC_WORD = 16'd180; // 264 octal, bits 8:2 only

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init_i = 1'b0, done_i = 1'b0, int_en_i = 1'b0, bbsy_in_i = 1'b0, ssyn_in_i = 1'b0;
  logic [NLV-1:0] bg_in_i = '0;
  logic [NLV-1:0] br_o, bg_out_o;
  logic sack_o, bbsy_o, intr_o;
  logic [15:0] data_o;

  int n_chk = 0, n_bad = 0;
  bit  ended = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_bus_requester u_irq_bus_requester (
    .clk(clk), .rst_n(rst_n), .init_i(init_i), .done_i(done_i), .int_en_i(int_en_i),
    .bg_in_i(bg_in_i), .bbsy_in_i(bbsy_in_i), .ssyn_in_i(ssyn_in_i),
    .br_o(br_o), .bg_out_o(bg_out_o), .sack_o(sack_o), .bbsy_o(bbsy_o),
    .intr_o(intr_o), .data_o(data_o)
  );

  // row: {done, ie, grant, bbsy_in, ssyn, exp_req, exp_sack, exp_own}
  localparam int NROWS = 11;
  localparam logic [7:0] ROWS [NROWS] = '{
    8'b11000_100, // R1 request raised
    8'b11100_010, // R3 grant edge claims
    8'b11110_010, // R4 other master busy, hold
    8'b11010_010, // R4 grant gone, still busy
    8'b11000_001, // R4 idle bus, take ownership
    8'b11000_001, // R5 keep owning
    8'b11001_000, // R6 slave sync edge releases
    8'b11000_000, // R6 inhibited
    8'b01000_000, // R6 done falls
    8'b11000_100, // R6 done rises, request again
    8'b10000_000  // R1 enable off
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic d, input logic ie, input logic g, input logic bb, input logic ss);
    @(negedge clk);
    done_i = d; int_en_i = ie; bg_in_i[LVL] = g; bbsy_in_i = bb; ssyn_in_i = ss;
  endtask

  task automatic step;
    @(posedge clk); #1;
  endtask

  task automatic finish_run;
    if (!ended) begin
      ended = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R7 reset state
    check("R7 reset br", 16'(br_o), 16'h0);
    check("R7 reset sack/own", {14'd0, sack_o, bbsy_o}, 16'h0);
    check("R5 reset data", data_o, 16'h0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NROWS; i++) begin
      logic [7:0] r;
      r = ROWS[i];
      drive(r[7], r[6], r[5], r[4], r[3]);
      step();
      check($sformatf("R1 row%0d br", i), 16'(br_o), r[2] ? 16'h0002 : 16'h0000);
      check($sformatf("R3 row%0d sack", i), 16'(sack_o), 16'(r[1]));
      check($sformatf("R4 row%0d own", i), {14'd0, bbsy_o, intr_o}, r[0] ? 16'h3 : 16'h0);
      check($sformatf("R5 row%0d data", i), data_o, r[0] ? VEC_WORD : 16'h0);
    end

    // R8 and R3: grant without request passes on, no claim
    drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    step();
    drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    bg_in_i[2] = 1'b1;
    step();
    check("R3 unrequested grant sack", 16'(sack_o), 16'h0);
    check("R8 grant passed own level", 16'(bg_out_o[LVL]), 16'h1);
    check("R8 grant passed other level", 16'(bg_out_o[2]), 16'h1);
    drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    bg_in_i[2] = 1'b0;
    step();

    // R4: slave sync high blocks taking ownership
    drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    step();
    drive(1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    step();
    check("R8 claimed grant blocked", 16'(bg_out_o[LVL]), 16'h0);
    drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    step();
    check("R4 ssyn high holds sack", 16'(sack_o), 16'h1);
    check("R4 ssyn high no own", 16'(bbsy_o), 16'h0);
    drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    step();
    check("R4 idle takes own", 16'(bbsy_o), 16'h1);

    // R7: init while owning
    @(negedge clk); init_i = 1'b1; #1;
    check("R7 init blocks request", 16'(br_o), 16'h0);
    step();
    check("R7 init clears own", {14'd0, sack_o, bbsy_o}, 16'h0);
    check("R7 init clears vector", data_o, 16'h0);
    @(negedge clk); init_i = 1'b0; #1;
    check("R1 request after init", 16'(br_o), 16'h0002);

    finish_run();
  end
endmodule